// File: doc/BRIEF.md
# Beam Trigger Handshake Controller

This block turns beam scintillator discriminator pulses into triggers for a single device under test (DUT). Four discriminated photomultiplier inputs are combined through an enable mask. A trigger is formed when every enabled input is high in the same clock cycle. Each trigger that is actually issued is delivered over one of three selectable handshakes: a plain fixed-length pulse, a trigger/busy exchange, or a trigger/data exchange. In the trigger/data exchange the DUT clocks the event number out of the block serially.

A free-running 48-bit timestamp counter and a 15-bit event counter run alongside the handshake. Each issued trigger pushes its timestamp and event number into a small FIFO. Software or downstream logic drains the FIFO, and an almost-full flag warns before the FIFO fills. Coincidences that cannot be issued are tallied in a separate 16-bit counter. A coincidence cannot be issued when the DUT holds its clock line high as a veto, when a handshake is still in progress, when busy is held, or when the FIFO is full.

Top module: `beam_trigger_ctrl`

## Requirements
- R1: A coincidence exists when the mask `pmt_mask` is non-zero and every input enabled in the mask is high in the same cycle. An all-zero mask never forms a trigger.
- R2: With `mode` = 0, each issued trigger drives `dut_trig` high for exactly `pulse_len` cycles, starting the cycle after the coincidence. A `pulse_len` of 0 selects 4 cycles. `dut_busy` has no effect in this mode.
- R3: With `mode` = 1 or 3, `dut_trig` rises the cycle after an issued coincidence. It drops the cycle after `dut_busy` is seen high. No new trigger is issued until `dut_busy` has been seen low again.
- R4: With `mode` = 2, `dut_trig` rises as in R3 and drops when busy is seen. While busy stays high, `dut_data` carries the 15-bit event number of that trigger, LSB first, and advances one bit on each synchronized rising edge of `dut_clk`. The transfer ends when busy is seen low. Outside the transfer, `dut_data` is 0.
- R5: In the idle state, a `dut_clk` level of 1 seen through a two-flop synchronizer blocks the issue of a trigger in every mode.
- R6: Each issued trigger writes one FIFO entry. The entry holds the timestamp counter value of the issuing cycle and the event number. The timestamp counter counts cycles from 0 after reset. `fifo_ts` and `fifo_evt` show the oldest entry, and `fifo_rd` pops it when the FIFO is not empty.
- R7: `evt_count` starts at 0 and increments by one for each issued trigger only. The first trigger carries event number 0.
- R8: `veto_count` increments by one for each coincidence cycle that does not issue a trigger.
- R9: `fifo_afull` is high while the FIFO holds at least 6 of its 8 entries. A full FIFO blocks the issue of triggers.
- R10: A synchronous reset clears both counters, the timestamp and the FIFO, and returns the block to idle with `dut_trig` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous reset, active high |
| pmt_in | input | 4 | Discriminated scintillator inputs |
| pmt_mask | input | 4 | Per-input coincidence enable |
| mode | input | 2 | Handshake select: 0 pulse, 2 trigger/data, other values trigger/busy |
| pulse_len | input | 8 | Pulse length in cycles for mode 0; 0 selects the default of 4 |
| dut_trig | output | 1 | Trigger to the DUT |
| dut_busy | input | 1 | Busy from the DUT |
| dut_clk | input | 1 | DUT clock line: veto when idle, shift clock in a transfer |
| dut_data | output | 1 | Serial event number to the DUT |
| fifo_rd | input | 1 | Pop the oldest FIFO entry |
| fifo_ts | output | 48 | Timestamp of the oldest entry |
| fifo_evt | output | 15 | Event number of the oldest entry |
| fifo_empty | output | 1 | FIFO holds no entry |
| fifo_afull | output | 1 | FIFO at or above the almost-full level |
| evt_count | output | 15 | Issued-trigger counter |
| veto_count | output | 16 | Blocked-coincidence counter |

## Verification
The bench uses the default parameters: an 8-entry FIFO with an almost-full level of 6, a default pulse of 4 cycles, and a 15-bit serial number. The small FIFO depth lets a short burst of mode-0 triggers with a one-cycle pulse both reach the almost-full level and fill the FIFO. The remaining coincidences of that burst go to the blocked counter. All three handshakes, the clock-line veto and a full 15-bit serial transfer then fit within a few hundred cycles.

// File: rtl/beam_trigger_ctrl.sv
module beam_trigger_ctrl #(
  parameter int TS_W      = 48,
  parameter int EVT_W     = 15,
  parameter int VETO_W    = 16,
  parameter int DEPTH     = 8,
  parameter int AFULL_LVL = 6,
  parameter int LEN_W     = 8,
  parameter int PULSE_DEF = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [3:0]        pmt_in,
  input  logic [3:0]        pmt_mask,
  input  logic [1:0]        mode,
  input  logic [LEN_W-1:0]  pulse_len,
  output logic              dut_trig,
  input  logic              dut_busy,
  input  logic              dut_clk,
  output logic              dut_data,
  input  logic              fifo_rd,
  output logic [TS_W-1:0]   fifo_ts,
  output logic [EVT_W-1:0]  fifo_evt,
  output logic              fifo_empty,
  output logic              fifo_afull,
  output logic [EVT_W-1:0]  evt_count,
  output logic [VETO_W-1:0] veto_count
);
  localparam int AW = $clog2(DEPTH);
  localparam int EW = TS_W + EVT_W;

  typedef enum logic [2:0] {S_IDLE, S_PULSE, S_WAIT, S_REL, S_SHIFT} st_t;
  st_t st;

  logic [TS_W-1:0]  ts;
  logic [LEN_W-1:0] cnt;
  logic [EVT_W-1:0] sh;
  logic             xfer;
  logic             ck1, ck2, ck3;
  logic [AW:0]      wp, rp;
  logic [EW-1:0]    mem [DEPTH];

  wire [AW:0] level   = wp - rp;
  wire        full    = level == (AW+1)'(DEPTH);
  wire        coinc   = (pmt_mask != 4'd0) && ((pmt_in & pmt_mask) == pmt_mask);
  wire        blk_bsy = (mode != 2'd0) && dut_busy;
  wire        issue   = (st == S_IDLE) && coinc && !full && !ck2 && !blk_bsy;
  wire        ck_rise = ck2 && !ck3;
  wire        pop     = fifo_rd && !fifo_empty;
  wire [LEN_W-1:0] len_eff = (pulse_len == '0) ? LEN_W'(PULSE_DEF) : pulse_len;

  assign dut_trig   = (st == S_PULSE) || (st == S_WAIT);
  assign dut_data   = (st == S_SHIFT) && sh[0];
  assign fifo_empty = level == '0;
  assign fifo_afull = level >= (AW+1)'(AFULL_LVL);
  assign {fifo_ts, fifo_evt} = mem[rp[AW-1:0]];

  always_ff @(posedge clk) begin
    if (rst) {ck1, ck2, ck3} <= '0;
    else     {ck1, ck2, ck3} <= {dut_clk, ck1, ck2};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ts <= '0; evt_count <= '0; veto_count <= '0;
    end else begin
      ts <= ts + 1'b1;
      if (issue) evt_count <= evt_count + 1'b1;
      if (coinc && !issue) veto_count <= veto_count + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wp <= '0; rp <= '0;
    end else begin
      if (issue) begin
        mem[wp[AW-1:0]] <= {ts, evt_count};
        wp <= wp + 1'b1;
      end
      if (pop) rp <= rp + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st <= S_IDLE; cnt <= '0; sh <= '0; xfer <= 1'b0;
    end else begin
      case (st)
        S_IDLE: if (issue) begin
          sh   <= evt_count;
          xfer <= (mode == 2'd2);
          cnt  <= len_eff - 1'b1;
          st   <= (mode == 2'd0) ? S_PULSE : S_WAIT;
        end
        S_PULSE: begin
          if (cnt == '0) st <= S_IDLE;
          else           cnt <= cnt - 1'b1;
        end
        S_WAIT:  if (dut_busy) st <= xfer ? S_SHIFT : S_REL;
        S_REL:   if (!dut_busy) st <= S_IDLE;
        S_SHIFT: begin
          if (!dut_busy)    st <= S_IDLE;
          else if (ck_rise) sh <= sh >> 1;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  assert_trig_rise_unvetoed_R5: assert property (@(posedge clk) disable iff (rst)
    $rose(dut_trig) |-> !$past(ck2));
  assert_trig_rise_stored_R6: assert property (@(posedge clk) disable iff (rst)
    $rose(dut_trig) |-> !fifo_empty);
  assert_evt_step_R7: assert property (@(posedge clk) disable iff (rst)
    $rose(dut_trig) |-> evt_count == $past(evt_count) + 1'b1);
  assert_fifo_bound_R9: assert property (@(posedge clk) disable iff (rst)
    level <= (AW+1)'(DEPTH));
  assert_released_low_R3: assert property (@(posedge clk) disable iff (rst)
    (st == S_REL) |-> !dut_trig);
  assert_shift_trig_low_R4: assert property (@(posedge clk) disable iff (rst)
    (st == S_SHIFT) |-> !dut_trig);
endmodule

// File: tb/beam_trigger_ctrl_tb.sv
module beam_trigger_ctrl_tb;
  logic        clk = 1'b0, rst = 1'b1;
  logic [3:0]  pmt_in = '0, pmt_mask = '0;
  logic [1:0]  mode = '0;
  logic [7:0]  pulse_len = '0;
  logic        dut_busy = 1'b0, dut_clk = 1'b0, fifo_rd = 1'b0;
  logic        dut_trig, dut_data, fifo_empty, fifo_afull;
  logic [47:0] fifo_ts;
  logic [14:0] fifo_evt, evt_count;
  logic [15:0] veto_count;

  beam_trigger_ctrl u_dut (.clk, .rst, .pmt_in, .pmt_mask, .mode, .pulse_len,
    .dut_trig, .dut_busy, .dut_clk, .dut_data, .fifo_rd, .fifo_ts, .fifo_evt,
    .fifo_empty, .fifo_afull, .evt_count, .veto_count);

  always #2 clk = ~clk;

  int vectors = 0, bad = 0, cycles = 0;
  int m_st = 0, m_cnt = 0;
  logic m_xfer = 0, s1 = 0, s2 = 0, s3 = 0;
  logic [14:0] m_sh = '0, m_evt = '0;
  logic [15:0] m_veto = '0;
  logic [47:0] m_ts = '0;
  logic [62:0] q[$];

  always @(posedge clk) begin
    if (rst) begin
      m_st = 0; m_cnt = 0; m_xfer = 0; s1 = 0; s2 = 0; s3 = 0;
      m_sh = '0; m_evt = '0; m_veto = '0; m_ts = '0; q.delete();
    end else begin
      logic co, iss, rise;
      co   = (pmt_mask != 0) && ((pmt_in & pmt_mask) == pmt_mask);
      iss  = (m_st == 0) && co && (q.size() < 8) && !s2 && !(mode != 0 && dut_busy);
      rise = s2 && !s3;
      if (fifo_rd && q.size() > 0) void'(q.pop_front());
      if (iss) q.push_back({m_ts, m_evt});
      if (co && !iss) m_veto++;
      case (m_st)
        0: if (iss) begin
             m_sh = m_evt; m_xfer = (mode == 2);
             m_cnt = (pulse_len == 0) ? 4 : int'(pulse_len);
             m_st = (mode == 0) ? 1 : 2;
           end
        1: begin m_cnt--; if (m_cnt == 0) m_st = 0; end
        2: if (dut_busy) m_st = m_xfer ? 4 : 3;
        3: if (!dut_busy) m_st = 0;
        default: if (!dut_busy) m_st = 0; else if (rise) m_sh = m_sh >> 1;
      endcase
      if (iss) m_evt++;
      m_ts++;
      s3 = s2; s2 = s1; s1 = dut_clk;
    end
  end

  task automatic chk(string req, string what, longint act, longint exp);
    vectors++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic cyc();
    @(negedge clk);
    chk("R1/R2/R3", "dut_trig", dut_trig, (m_st == 1 || m_st == 2));
    chk("R4", "dut_data", dut_data, (m_st == 4) ? m_sh[0] : 1'b0);
    chk("R7", "evt_count", evt_count, m_evt);
    chk("R8/R5", "veto_count", veto_count, m_veto);
    chk("R6", "fifo_empty", fifo_empty, q.size() == 0);
    chk("R9", "fifo_afull", fifo_afull, q.size() >= 6);
    if (q.size() > 0) begin
      chk("R6", "fifo_ts", fifo_ts, q[0][62:15]);
      chk("R6", "fifo_evt", fifo_evt, q[0][14:0]);
    end
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) cyc();
  endtask

  task automatic hit(logic [3:0] p);
    pmt_in = p; cyc(); pmt_in = '0;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000) begin
      bad++;
      $display("FAIL watchdog: actual %0d cycles expected fewer", cycles);
      $display("== %0d vectors applied, %0d miscompares ==", vectors, bad);
      $finish;
    end
  end

  initial begin
    idle(3);
    rst = 0;
    cyc();
    // R10 reset state
    chk("R10", "trig after reset", dut_trig, 0);
    chk("R10", "empty after reset", fifo_empty, 1);
    chk("R10", "evt after reset", evt_count, 0);
    // R1 mask: zero mask, partial pattern, full match
    pmt_mask = 4'b0000; hit(4'b1111); idle(3);
    pmt_mask = 4'b0101; hit(4'b0100); idle(3);
    hit(4'b1101); idle(6);
    // R2 default length, explicit length, busy ignored
    pulse_len = 8'd7; dut_busy = 1; hit(4'b0101); idle(9); dut_busy = 0;
    hit(4'b0101); hit(4'b0101); idle(9);
    // R5 clock-line veto while idle
    pulse_len = 0; dut_clk = 1; idle(3); hit(4'b0101); idle(2); dut_clk = 0; idle(3);
    // R3 trigger/busy handshake with blocked coincidence
    mode = 1; hit(4'b0101); idle(3); dut_busy = 1; idle(2);
    hit(4'b0101); idle(2); dut_busy = 0; idle(2); hit(4'b0101); idle(2);
    dut_busy = 1; idle(2); dut_busy = 0; idle(3);
    // R4 trigger/data transfer of a full number
    mode = 2; hit(4'b0101); idle(2); dut_busy = 1; idle(2);
    for (int b = 0; b < 16; b++) begin
      dut_clk = 1; idle(3); dut_clk = 0; idle(3);
    end
    dut_busy = 0; idle(4);
    // drain, then R9 fill with short pulses
    fifo_rd = 1; idle(10); fifo_rd = 0;
    mode = 0; pulse_len = 8'd1;
    for (int k = 0; k < 11; k++) begin hit(4'b0101); idle(2); end
    idle(2);
    fifo_rd = 1; idle(10); fifo_rd = 0; idle(2);
    // R10 mid-run reset
    hit(4'b0101); rst = 1; cyc(); cyc(); rst = 0; idle(2);
    chk("R10", "evt after reset", evt_count, 0);
    chk("R10", "veto after reset", veto_count, 0);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, bad);
    $finish;
  end
endmodule